// File: doc/BRIEF.md
# Preset-Bank Step Attenuator Controller

This block drives the five stage-enable lines of a binary-weighted step attenuator (stages of 1, 2, 4, 8 and 16 dB, so 0 to 31 dB in 1 dB steps). It offers two control paths, chosen by a mode input. The direct path takes a 5-bit code from parallel pins and registers it onto the output. The serial path loads a bank of four preset codes through a three-wire port: an active-low chip select, a shift clock and a data line. Two select pins then switch the output between those presets with no further serial traffic. This suits fast gain changes, such as stepping in attenuation when a strong blocker appears.

The serial pins are treated as asynchronous. They are brought into the system clock domain by a synchronizer, and rising shift-clock edges are detected there. A loader state machine has three states. LD_IDLE is the state while select is high. LD_SHIFT is the state while a frame is being received and counted. LD_DROP is the state once a frame has overrun its length. The transitions are as follows. IDLE moves to SHIFT when select falls, and the bit counter is cleared. SHIFT moves to IDLE when select rises; the bank is committed if and only if exactly the frame length of bits was counted. SHIFT moves to DROP on a shift edge that arrives after the frame is already full. DROP moves to IDLE when select rises, and nothing is committed. The output register samples the mode, select and parallel pins directly, so a change on any of them appears after one system clock.

Top module: `stepatt_ctrl`

## Requirements
- R1: A synchronous reset drives stage_en to 0 and clears all four presets to 0. After reset, serial mode shows 0 for every select value.
- R2: With mode_serial=0, stage_en equals par_code as sampled at the previous rising clk edge. Bit k of the code enables the stage of 2^k dB, and a 1 means enabled.
- R3: With mode_serial=1, stage_en at the next clock equals the preset chosen by preset_sel. preset_sel[0] is the A pin and preset_sel[1] is the B pin. The values 00, 01, 10 and 11 (written {B,A}) pick presets 1, 2, 3 and 4.
- R4: A serial frame is 28 bits. Each bit is taken from sdata on a rising sclk edge while scs_n is low, most significant bit first. The bits arrive in this order: 8 reserved bits, then the 5-bit codes of preset 4, preset 3, preset 2 and preset 1, each code MSB first.
- R5: The stored presets change only when scs_n rises. While a frame is being shifted, stage_en keeps showing the old preset.
- R6: If scs_n rises after any count of sclk rising edges other than 28 (for example 27 or 29), the frame is discarded and all presets keep their previous values.
- R7: The values of the 8 reserved bits have no effect on the presets loaded.
- R8: While mode_serial=0, the presets are retained, and serial traffic does not change stage_en. A frame received in that mode becomes visible once mode_serial returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_serial | input | 1 | 0: parallel path, 1: preset path |
| par_code | input | 5 | Direct attenuation code |
| preset_sel | input | 2 | Preset select, bit 0 = A, bit 1 = B |
| scs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| stage_en | output | 5 | Registered stage-enable word |

## Verification
The bench builds the block with its default parameters: 5-bit codes, four presets, 8 reserved bits (a 28-bit frame) and a two-stage synchronizer. These defaults make every one of the 32 parallel codes and all four select values quick to sweep. They also put both neighbours of the exact frame length, 27 and 29 edges, in reach of a short run. A behavioural model follows the pin-to-commit latency through the synchronizer and compares stage_en on every clock. This covers the intervals inside a frame, where the old preset must hold.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_DROP  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/stepatt_loader.sv
module stepatt_loader
    import stepatt_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int NUM_PRESETS = 4,
    parameter int RSV_BITS    = 8,
    localparam int BANK_W     = CODE_W * NUM_PRESETS,
    localparam int FRAME_BITS = RSV_BITS + BANK_W,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic [BANK_W-1:0] bank_o,
    output ld_state_e         state_o,
    output logic [CNT_W-1:0]  cnt_o
);

    ld_state_e         state_q, state_d;
    logic              sclk_prev;
    logic              sclk_rise;
    logic [BANK_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BANK_W-1:0] bank_q;
    logic              frame_full;
    logic              do_clear, do_shift, do_commit;

    assign sclk_rise  = sclk_s & ~sclk_prev;
    assign frame_full = (cnt_q == CNT_W'(FRAME_BITS));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LD_IDLE;
        else     state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        do_clear  = 1'b0;
        do_shift  = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (!cs_n_s) begin
                    state_d  = LD_SHIFT;
                    do_clear = 1'b1;
                end
            end
            LD_SHIFT: begin
                if (cs_n_s) begin
                    state_d   = LD_IDLE;
                    do_commit = frame_full;
                end else if (sclk_rise) begin
                    if (frame_full) state_d  = LD_DROP;
                    else            do_shift = 1'b1;
                end
            end
            LD_DROP: begin
                if (cs_n_s) state_d = LD_IDLE;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // edge detector, shift register, counter and preset bank
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            shreg_q   <= '0;
            cnt_q     <= '0;
            bank_q    <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (do_clear) begin
                cnt_q <= '0;
            end else if (do_shift) begin
                shreg_q <= {shreg_q[BANK_W-2:0], sdata_s};
                cnt_q   <= cnt_q + CNT_W'(1);
            end
            if (do_commit) bank_q <= shreg_q;
        end
    end

    assign bank_o  = bank_q;
    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/stepatt_outreg.sv
module stepatt_outreg #(
    parameter int CODE_W      = 5,
    parameter int NUM_PRESETS = 4,
    localparam int BANK_W     = CODE_W * NUM_PRESETS,
    localparam int SEL_W      = $clog2(NUM_PRESETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_serial,
    input  logic [CODE_W-1:0] par_code,
    input  logic [SEL_W-1:0]  preset_sel,
    input  logic [BANK_W-1:0] bank,
    output logic [CODE_W-1:0] stage_en
);

    logic [CODE_W-1:0] presets [NUM_PRESETS];
    logic [CODE_W-1:0] next_code;

    for (genvar i = 0; i < NUM_PRESETS; i++) begin : g_unpack
        assign presets[i] = bank[i*CODE_W +: CODE_W];
    end

    always_comb begin
        if (mode_serial) next_code = presets[preset_sel];
        else             next_code = par_code;
    end

    always_ff @(posedge clk) begin
        if (rst) stage_en <= '0;
        else     stage_en <= next_code;
    end

endmodule

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
    import stepatt_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int NUM_PRESETS = 4,
    parameter int RSV_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BANK_W     = CODE_W * NUM_PRESETS,
    localparam int FRAME_BITS = RSV_BITS + BANK_W,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1),
    localparam int SEL_W      = $clog2(NUM_PRESETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_serial,
    input  logic [CODE_W-1:0] par_code,
    input  logic [SEL_W-1:0]  preset_sel,
    input  logic              scs_n,
    input  logic              sclk,
    input  logic              sdata,
    output logic [CODE_W-1:0] stage_en
);

    logic [2:0]        ser_s;
    logic              cs_s, sclk_s, sdata_s;
    logic [BANK_W-1:0] bank;
    ld_state_e         ld_state;
    logic [CNT_W-1:0]  ld_cnt;

    stepatt_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({scs_n, sclk, sdata}),
        .q   (ser_s)
    );

    assign cs_s    = ser_s[2];
    assign sclk_s  = ser_s[1];
    assign sdata_s = ser_s[0];

    stepatt_loader #(
        .CODE_W      (CODE_W),
        .NUM_PRESETS (NUM_PRESETS),
        .RSV_BITS    (RSV_BITS)
    ) loader_i (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (cs_s),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .bank_o  (bank),
        .state_o (ld_state),
        .cnt_o   (ld_cnt)
    );

    stepatt_outreg #(
        .CODE_W      (CODE_W),
        .NUM_PRESETS (NUM_PRESETS)
    ) outreg_i (
        .clk         (clk),
        .rst         (rst),
        .mode_serial (mode_serial),
        .par_code    (par_code),
        .preset_sel  (preset_sel),
        .bank        (bank),
        .stage_en    (stage_en)
    );

endmodule

// File: rtl/stepatt_ctrl_chk.sv
module stepatt_ctrl_chk
    import stepatt_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int NUM_PRESETS = 4,
    parameter int FRAME_BITS  = 28,
    localparam int BANK_W     = CODE_W * NUM_PRESETS,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1),
    localparam int SEL_W      = $clog2(NUM_PRESETS)
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_serial,
    input logic [CODE_W-1:0] par_code,
    input logic [SEL_W-1:0]  preset_sel,
    input logic [CODE_W-1:0] stage_en,
    input logic [BANK_W-1:0] bank,
    input ld_state_e         ld_state,
    input logic [CNT_W-1:0]  ld_cnt,
    input logic              cs_s
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stage_en == '0) && (bank == '0));

    // R2
    parallel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_serial |=> stage_en == $past(par_code));

    // R3
    serial_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mode_serial |=> stage_en == $past(bank[preset_sel*CODE_W +: CODE_W]));

    // R5
    bank_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank) |-> $past(cs_s) && ($past(ld_state) == LD_SHIFT));

    // R6
    bank_length_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank) |-> $past(ld_cnt) == CNT_W'(FRAME_BITS));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ld_cnt <= CNT_W'(FRAME_BITS));

endmodule

bind stepatt_ctrl stepatt_ctrl_chk #(
    .CODE_W      (CODE_W),
    .NUM_PRESETS (NUM_PRESETS),
    .FRAME_BITS  (FRAME_BITS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_serial (mode_serial),
    .par_code    (par_code),
    .preset_sel  (preset_sel),
    .stage_en    (stage_en),
    .bank        (bank),
    .ld_state    (ld_state),
    .ld_cnt      (ld_cnt),
    .cs_s        (cs_s)
);

// File: tb/stepatt_ctrl_tb_top.sv
module stepatt_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_serial = 1'b0;
    logic [4:0] par_code = '0;
    logic [1:0] preset_sel = '0;
    logic       scs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [4:0] stage_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    stepatt_ctrl dut_i (
        .clk (clk), .rst (rst), .mode_serial (mode_serial),
        .par_code (par_code), .preset_sel (preset_sel),
        .scs_n (scs_n), .sclk (sclk), .sdata (sdata),
        .stage_en (stage_en)
    );

    // behavioural reference: pins seen two clocks late, frame rules applied
    logic       m_cs [4];
    logic       m_ck [4];
    logic       m_dt [3];
    int         m_count;
    logic [27:0] m_bits;
    logic [4:0] m_pre [4];
    logic [4:0] exp_q;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < 4; i++) begin m_cs[i] = 1'b1; m_ck[i] = 1'b0; end
            for (int i = 1; i < 3; i++) m_dt[i] = 1'b0;
            m_count = 0;
            m_bits  = '0;
            for (int i = 0; i < 4; i++) m_pre[i] = '0;
            exp_q = '0;
        end else begin
            exp_q = mode_serial ? m_pre[preset_sel] : par_code;
            if (m_cs[2] && !m_cs[3] && m_count == 28)
                for (int i = 0; i < 4; i++) m_pre[i] = m_bits[i*5 +: 5];
            if (!m_cs[2] && m_cs[3]) m_count = 0;
            else if (!m_cs[2] && !m_cs[3] && m_ck[2] && !m_ck[3]) begin
                m_bits  = {m_bits[26:0], m_dt[2]};
                m_count = m_count + 1;
            end
            m_cs[3] = m_cs[2]; m_cs[2] = m_cs[1]; m_cs[1] = scs_n;
            m_ck[3] = m_ck[2]; m_ck[2] = m_ck[1]; m_ck[1] = sclk;
            m_dt[2] = m_dt[1]; m_dt[1] = sdata;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (stage_en !== exp_q) begin
                errors++;
                $display("FAIL %s model compare: stage_en=%0d expected=%0d at %0t",
                         cur_req, stage_en, exp_q, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(input logic [4:0] exp, input string req);
        checks++;
        if (stage_en !== exp) begin
            errors++;
            $display("FAIL %s: stage_en=%0d expected=%0d at %0t", req, stage_en, exp, $time);
        end
    endtask

    function automatic logic [27:0] make_frame(input logic [7:0] rsv, input logic [4:0] p1,
        input logic [4:0] p2, input logic [4:0] p3, input logic [4:0] p4);
        return {rsv, p4, p3, p2, p1};
    endfunction

    task automatic send_frame(input logic [27:0] fr, input int nedges,
                              input bit chk_hold, input logic [4:0] hold_val, input string req);
        @(negedge clk);
        scs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nedges; i++) begin
            sdata = (i < 28) ? fr[27-i] : 1'b0;
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
        wait_clk(6);
        if (chk_hold) check_out(hold_val, req);
        scs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic check_presets(input logic [4:0] e0, input logic [4:0] e1,
                                 input logic [4:0] e2, input logic [4:0] e3, input string req);
        logic [4:0] ev [4];
        ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
        mode_serial = 1'b1;
        for (int s = 0; s < 4; s++) begin
            preset_sel = 2'(s);
            wait_clk(1);
            check_out(ev[s], req);
        end
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);

        cur_req = "R1";
        check_out(5'd0, "R1 reset output");
        check_presets(0, 0, 0, 0, "R1 presets cleared");

        cur_req = "R2";
        mode_serial = 1'b0;
        for (int c = 0; c < 32; c++) begin
            par_code = 5'(c);
            wait_clk(1);
            check_out(5'(c), "R2 parallel code");
        end

        cur_req = "R4";
        mode_serial = 1'b1;
        preset_sel  = 2'b00;
        send_frame(make_frame(8'h00, 5'd3, 5'd17, 5'd30, 5'd31), 28, 1'b1, 5'd0, "R5 hold during shift");
        check_presets(5'd3, 5'd17, 5'd30, 5'd31, "R4 frame layout");

        cur_req = "R3";
        preset_sel = 2'b01; wait_clk(1); check_out(5'd17, "R3 A=1 B=0 preset 2");
        preset_sel = 2'b10; wait_clk(1); check_out(5'd30, "R3 A=0 B=1 preset 3");
        preset_sel = 2'b00; wait_clk(1); check_out(5'd3,  "R3 A=0 B=0 preset 1");

        cur_req = "R6";
        preset_sel = 2'b11;
        send_frame(make_frame(8'h00, 5'd1, 5'd2, 5'd4, 5'd8), 27, 1'b0, 5'd0, "R6");
        check_presets(5'd3, 5'd17, 5'd30, 5'd31, "R6 short frame discarded");
        send_frame(make_frame(8'h00, 5'd1, 5'd2, 5'd4, 5'd8), 29, 1'b0, 5'd0, "R6");
        check_presets(5'd3, 5'd17, 5'd30, 5'd31, "R6 long frame discarded");

        cur_req = "R7";
        send_frame(make_frame(8'hFF, 5'd10, 5'd21, 5'd5, 5'd16), 28, 1'b0, 5'd0, "R7");
        check_presets(5'd10, 5'd21, 5'd5, 5'd16, "R7 reserved ignored");

        cur_req = "R8";
        mode_serial = 1'b0;
        par_code = 5'd9;
        send_frame(make_frame(8'h00, 5'd6, 5'd7, 5'd11, 5'd12), 28, 1'b1, 5'd9, "R8 parallel during frame");
        check_out(5'd9, "R8 parallel after frame");
        check_presets(5'd6, 5'd7, 5'd11, 5'd12, "R8 frame loaded in parallel mode");
        mode_serial = 1'b0;
        par_code = 5'd25;
        wait_clk(10);
        check_out(5'd25, "R8 parallel again");
        check_presets(5'd6, 5'd7, 5'd11, 5'd12, "R8 presets retained");

        cur_req = "R1";
        @(negedge clk);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);
        check_out(5'd0, "R1 second reset output");
        check_presets(0, 0, 0, 0, "R1 second reset presets");

        wait_clk(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule